// File: doc/BRIEF.md
# Fast Serial Readout Latch with Automatic Convert Start

This block keeps the result of the last finished conversion in a local shift register. Readout logic can then clock that result out serially on its own readout clock, which may run faster than the conversion clock, while the next conversion proceeds. Readout logic drives a latch control input that is synchronous to the readout clock. A high-to-low transition of that input is the capture event. On the readout-clock rising edge that first samples it low, the 16-bit SAR result is copied into the shift register. The result is then shifted out MSB first, one bit per readout edge.

The same capture event is the only source of conversion starts. In the readout domain it flips a request toggle. The toggle crosses to the conversion-clock domain through a synchronizer, where it becomes a one-cycle start pulse for the sequencer. The sequencer side returns an acknowledge toggle. The sequencer reports through a level whether the SAR still holds a finished result. If that level has dropped by the capture event, the capture came too late: nothing is loaded and an error flag is raised. The flag stays set until a later capture succeeds.

Top module: `fastread_latch`

## Requirements
- R1: While either reset is held, and at the first sample after both resets are released, `ser_out`, `late_err` and `conv_start` are all 0.
- R2: A capture event is a `rd_clk` rising edge at which `latch_n` is sampled 0 after being sampled 1 at the previous edge. Holding `latch_n` at 0 gives no further event, even if `sar_data` changes.
- R3: After a successful capture, `ser_out` shows bit 15 of the captured word from that edge on. Each later `rd_clk` rising edge presents the next lower bit (MSB first).
- R4: Once bit 0 is presented, `ser_out` holds it until the next successful capture.
- R5: A successful capture that arrives while a word is still being shifted restarts the output at bit 15 of the new word.
- R6: `sar_valid` = 1 means the SAR holds a finished result. It passes through a 2-stage synchronizer into the readout domain. If the synchronized level is 0 at a capture event, the shift register is not loaded (the `ser_out` sequence continues unchanged) and `late_err` becomes 1.
- R7: `late_err` stays 1 until the next successful capture, which clears it. Only capture events change it.
- R8: Each capture event, successful or late, that finds no start request outstanding produces exactly one `conv_start` pulse. The pulse is one `cv_clk` cycle long.
- R9: A capture event that arrives while the previous start request is still unacknowledged still performs its capture, but produces no additional `conv_start`.
- R10: There is no external convert input. With no capture event, `conv_start` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rd_clk | input | 1 | Readout clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, readout domain |
| latch_n | input | 1 | Latch control, synchronous to rd_clk; a falling transition is a capture event |
| ser_out | output | 1 | Serial result, MSB first |
| late_err | output | 1 | Set by a capture that found the SAR already cleared |
| cv_clk | input | 1 | Conversion clock |
| cv_rst_n | input | 1 | Synchronous active-low reset, conversion domain |
| sar_valid | input | 1 | High while the SAR holds a finished, stable result |
| sar_data | input | 16 | SAR result word |
| conv_start | output | 1 | One-cycle conversion start to the sequencer, cv_clk domain |

## Verification
Two functions can fall on the same readout edge. A new capture can land while the previous word is still being shifted out. A capture event can also arrive while the previous start request is still crossing the clock domains. The bench provokes both at once by driving `latch_n` low, high, then low again across three readout edges. It then expects the serial stream to restart at bit 15 of the second word after two bits of the first, and the count of `conv_start` pulses to grow by exactly one. Random rounds also mix late captures, long low holds and partial shifts, and compare every serial bit and every pulse count against a bench model of the shifting.

// File: rtl/fr_pkg.sv
// Shared types for the fast readout latch.
// Assumes nothing beyond a standard SystemVerilog compile order (this file first).
package fr_pkg;

    // Outcome of a readout-domain capture event.
    typedef enum logic [1:0] {
        CAP_NONE = 2'd0,
        CAP_OK   = 2'd1,
        CAP_LATE = 2'd2
    } cap_res_e;

    // Default word width and synchronizer depth.
    localparam int unsigned FR_DATA_W_DEF = 16;
    localparam int unsigned FR_SYNC_DEF   = 2;

endpackage

// File: rtl/fr_sync.sv
// Single-bit multi-flop synchronizer.
// Takes a level or toggle from another clock domain and re-times it into clk.
// Assumes STAGES >= 2 and a source that holds each value for several clk cycles.
module fr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // First stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each later stage re-samples the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/fr_capture_ctl.sv
// Capture qualifier in the readout domain.
// Finds the falling transition of the latch control and classifies it as a good
// or a late capture from the synchronized SAR-valid level. Keeps the late flag.
// Assumes latch_n is synchronous to clk.
module fr_capture_ctl
    import fr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     latch_n,
    input  logic     valid_s,
    output logic     cap_evt,
    output cap_res_e cap_res,
    output logic     late_err
);

    logic latch_q;

    // Remember the previous sampled latch level (idle high).
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= 1'b1;
        else        latch_q <= latch_n;
    end

    assign cap_evt = latch_q & ~latch_n;

    // Classify the event from the synchronized SAR-valid level.
    always_comb begin
        cap_res = CAP_NONE;
        if (cap_evt) cap_res = valid_s ? CAP_OK : CAP_LATE;
    end

    // Late flag: set by a late capture, cleared by a good one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            late_err <= 1'b0;
        end else begin
            case (cap_res)
                CAP_OK:   late_err <= 1'b0;
                CAP_LATE: late_err <= 1'b1;
                default:  late_err <= late_err;
            endcase
        end
    end

endmodule

// File: rtl/fr_shifter.sv
// Parallel-load, MSB-first shift register with a stop at the last bit.
// A load presents the top bit at once; each following edge moves one bit until
// bit 0 is reached, which is then held.
// Assumes DATA_W >= 2.
module fr_shifter #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic              ser_out,
    output logic              done
);

    localparam int unsigned CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] sr;
    logic [CNT_W-1:0]  pos;

    assign done    = (pos == LAST);
    assign ser_out = sr[DATA_W-1];

    // Load a new word, or advance one bit until the end is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            pos <= LAST;
        end else if (load) begin
            sr  <= din;
            pos <= '0;
        end else if (!done) begin
            sr  <= {sr[DATA_W-2:0], 1'b0};
            pos <= pos + 1'b1;
        end
    end

endmodule

// File: rtl/fr_req_tx.sv
// Readout-side half of the convert-start handshake.
// Flips a request toggle on a capture event unless a request is still waiting
// for its acknowledge, in which case the event does not start a conversion.
// Assumes ack_tgl comes from the conversion domain and follows req_tgl.
module fr_req_tx #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic ack_tgl,
    output logic req_tgl
);

    logic ack_s;
    logic busy;

    fr_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    assign busy = req_tgl ^ ack_s;

    // Issue a new request only when the last one has been acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)            req_tgl <= 1'b0;
        else if (fire && !busy) req_tgl <= ~req_tgl;
    end

endmodule

// File: rtl/fr_req_rx.sv
// Conversion-side half of the convert-start handshake.
// Re-times the request toggle, emits a one-cycle start on each change and
// returns the consumed toggle state as the acknowledge.
// Assumes the request toggle changes at most once per handshake round trip.
module fr_req_rx #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_tgl,
    output logic start,
    output logic ack_tgl
);

    logic req_s;
    logic seen;

    fr_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    // Detect a toggle change and register it as the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen  <= 1'b0;
            start <= 1'b0;
        end else begin
            seen  <= req_s;
            start <= req_s ^ seen;
        end
    end

    assign ack_tgl = seen;

endmodule

// File: rtl/fastread_latch.sv
// Fast serial readout latch with automatic convert start.
// Holds the previous SAR result for MSB-first readout on rd_clk, flags captures
// that came after the SAR cleared, and sends one convert start per capture
// event into the cv_clk domain.
// Assumes latch_n is synchronous to rd_clk and sar_data is stable while
// sar_valid is high.
module fastread_latch
    import fr_pkg::*;
#(
    parameter int unsigned DATA_W      = FR_DATA_W_DEF,
    parameter int unsigned SYNC_STAGES = FR_SYNC_DEF
) (
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              latch_n,
    output logic              ser_out,
    output logic              late_err,
    input  logic              cv_clk,
    input  logic              cv_rst_n,
    input  logic              sar_valid,
    input  logic [DATA_W-1:0] sar_data,
    output logic              conv_start
);

    logic     valid_s;
    logic     cap_evt;
    cap_res_e cap_res;
    logic     shift_done;
    logic     req_tgl;
    logic     ack_tgl;

    // Bring the SAR-valid level into the readout domain.
    fr_sync #(.STAGES(SYNC_STAGES)) u_valid_sync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (sar_valid),
        .q     (valid_s)
    );

    fr_capture_ctl u_cap (
        .clk      (rd_clk),
        .rst_n    (rd_rst_n),
        .latch_n  (latch_n),
        .valid_s  (valid_s),
        .cap_evt  (cap_evt),
        .cap_res  (cap_res),
        .late_err (late_err)
    );

    fr_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .load    (cap_res == CAP_OK),
        .din     (sar_data),
        .ser_out (ser_out),
        .done    (shift_done)
    );

    fr_req_tx #(.SYNC_STAGES(SYNC_STAGES)) u_req_tx (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .fire    (cap_evt),
        .ack_tgl (ack_tgl),
        .req_tgl (req_tgl)
    );

    fr_req_rx #(.SYNC_STAGES(SYNC_STAGES)) u_req_rx (
        .clk     (cv_clk),
        .rst_n   (cv_rst_n),
        .req_tgl (req_tgl),
        .start   (conv_start),
        .ack_tgl (ack_tgl)
    );

endmodule

// File: rtl/fastread_latch_chk.sv
// Property checker for fastread_latch, attached with bind below.
// Assumes it sees the top's ports plus the capture event and shift-done wires.
module fastread_latch_chk (
    input logic rd_clk,
    input logic rd_rst_n,
    input logic cv_clk,
    input logic cv_rst_n,
    input logic ser_out,
    input logic late_err,
    input logic conv_start,
    input logic cap_evt,
    input logic shift_done
);

    // R8: a start pulse lasts one conversion-clock cycle.
    assert_start_one_cycle_R8: assert property (
        @(posedge cv_clk) disable iff (!cv_rst_n)
        conv_start |=> !conv_start
    );

    // R7: the late flag only rises on a capture event.
    assert_late_set_on_event_R7: assert property (
        @(posedge rd_clk) disable iff (!rd_rst_n)
        $rose(late_err) |-> $past(cap_evt)
    );

    // R7: the late flag only clears on a capture event.
    assert_late_clr_on_event_R7: assert property (
        @(posedge rd_clk) disable iff (!rd_rst_n)
        $fell(late_err) |-> $past(cap_evt)
    );

    // R4: after the last bit, the output holds while no capture occurs.
    assert_hold_last_bit_R4: assert property (
        @(posedge rd_clk) disable iff (!rd_rst_n)
        (shift_done && !cap_evt) |=> $stable(ser_out)
    );

endmodule

bind fastread_latch fastread_latch_chk u_chk (
    .rd_clk     (rd_clk),
    .rd_rst_n   (rd_rst_n),
    .cv_clk     (cv_clk),
    .cv_rst_n   (cv_rst_n),
    .ser_out    (ser_out),
    .late_err   (late_err),
    .conv_start (conv_start),
    .cap_evt    (cap_evt),
    .shift_done (shift_done)
);

// File: tb/fastread_latch_test.sv
module fastread_latch_test;

    logic        rd_clk = 1'b0;
    logic        cv_clk = 1'b0;
    logic        rd_rst_n = 1'b0;
    logic        cv_rst_n = 1'b0;
    logic        latch_n = 1'b1;
    logic        sar_valid = 1'b0;
    logic [15:0] sar_data = '0;
    logic        ser_out;
    logic        late_err;
    logic        conv_start;

    int checks = 0;
    int fails  = 0;
    int n_conv = 0;
    int exp_conv = 0;
    bit finished = 0;

    // Bench model of the serial stream.
    logic [15:0] m_word = '0;
    int          m_idx  = 15;
    logic        m_late = 1'b0;

    fastread_latch uut (
        .rd_clk     (rd_clk),
        .rd_rst_n   (rd_rst_n),
        .latch_n    (latch_n),
        .ser_out    (ser_out),
        .late_err   (late_err),
        .cv_clk     (cv_clk),
        .cv_rst_n   (cv_rst_n),
        .sar_valid  (sar_valid),
        .sar_data   (sar_data),
        .conv_start (conv_start)
    );

    always #4 rd_clk = ~rd_clk;
    initial begin
        #3;
        forever #10 cv_clk = ~cv_clk;
    end

    // Count start pulses, sampled away from the cv_clk active edge.
    always @(negedge cv_clk) if (cv_rst_n && conv_start) n_conv++;

    function automatic logic exp_bit(input logic [15:0] w, input int idx);
        return w[15 - idx];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One rd_clk edge without a capture; compare serial bit and flag.
    task automatic idle_step(input string tag);
        @(negedge rd_clk);
        if (m_idx < 15) m_idx++;
        chk(ser_out == exp_bit(m_word, m_idx), tag, ser_out, exp_bit(m_word, m_idx));
        chk(late_err == m_late, "R7 late flag held", late_err, m_late);
    endtask

    // Full capture: set data, wait, drop latch, hold it low, release, run tail.
    task automatic capture(input logic [15:0] d, input bit v, input int hold, input int tail);
        sar_data  = d;
        sar_valid = v;
        for (int i = 0; i < 4; i++) idle_step("R4 hold between captures");
        latch_n = 1'b0;
        @(negedge rd_clk);
        if (v) begin
            m_word = d; m_idx = 0; m_late = 1'b0;
        end else begin
            if (m_idx < 15) m_idx++;
            m_late = 1'b1;
        end
        exp_conv++;
        chk(ser_out == exp_bit(m_word, m_idx), v ? "R3 first bit is MSB" : "R6 late capture no load",
            ser_out, exp_bit(m_word, m_idx));
        chk(late_err == m_late, v ? "R7 good capture clears flag" : "R6 late flag set", late_err, m_late);
        sar_data = ~d;
        for (int i = 0; i < hold; i++) idle_step("R2 no recapture while low");
        latch_n = 1'b1;
        for (int i = 0; i < tail; i++) idle_step("R3 serial bit order");
        chk(n_conv == exp_conv, "R8 one start per event", n_conv, exp_conv);
    endtask

    initial begin
        void'($urandom(32'h0BAD_5EED));
        repeat (5) @(negedge rd_clk);
        chk(ser_out == 1'b0 && late_err == 1'b0 && conv_start == 1'b0, "R1 outputs in reset",
            {ser_out, late_err, conv_start}, 0);
        rd_rst_n = 1'b1;
        cv_rst_n = 1'b1;
        @(negedge rd_clk);
        chk(ser_out == 1'b0 && late_err == 1'b0 && conv_start == 1'b0, "R1 outputs after reset",
            {ser_out, late_err, conv_start}, 0);

        // Directed: plain good capture, full word plus hold.
        capture(16'hA5C3, 1'b1, 0, 22);
        // Directed: latch held low long with data changing.
        capture(16'h8001, 1'b1, 6, 20);
        // Directed: late capture, flag persists, then cleared by a good one.
        sar_valid = 1'b0;
        capture(16'h1234, 1'b0, 0, 20);
        capture(16'hFFFF, 1'b0, 2, 5);
        capture(16'h7E18, 1'b1, 0, 20);

        // Directed: R10, no event, no start pulse.
        for (int i = 0; i < 40; i++) begin
            sar_data  = 16'($urandom);
            sar_valid = ($urandom % 2) != 0;
            idle_step("R10 idle stream");
        end
        chk(n_conv == exp_conv, "R10 no start without event", n_conv, exp_conv);

        // Directed: R5 plus R9, second capture two edges after the first.
        sar_valid = 1'b1;
        sar_data  = 16'hC00C;
        for (int i = 0; i < 4; i++) idle_step("R4 hold before double");
        latch_n = 1'b0;
        @(negedge rd_clk);
        m_word = 16'hC00C; m_idx = 0; exp_conv++;
        chk(ser_out == 1'b1, "R3 first of double", ser_out, 1);
        latch_n = 1'b1;
        sar_data = 16'h3FF3;
        @(negedge rd_clk);
        m_idx = 1;
        chk(ser_out == exp_bit(m_word, 1), "R3 second bit of double", ser_out, exp_bit(m_word, 1));
        latch_n = 1'b0;
        @(negedge rd_clk);
        m_word = 16'h3FF3; m_idx = 0;
        chk(ser_out == 1'b0, "R5 restart at MSB of new word", ser_out, 0);
        latch_n = 1'b1;
        for (int i = 0; i < 20; i++) idle_step("R5 new word stream");
        chk(n_conv == exp_conv, "R9 busy event adds no start", n_conv, exp_conv);

        // Random rounds.
        for (int r = 0; r < 24; r++) begin
            capture(16'($urandom), ($urandom % 5) != 0, $urandom % 5, 10 + ($urandom % 14));
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #800000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule